// File: doc/BRIEF.md
# Operate-Format Integer ALU

This block is the combinational 64-bit integer execution stage for register-to-register and register-literal instructions in two opcode groups. One group does arithmetic: 32-bit and 64-bit add, subtract, add and subtract with operand A scaled by 4 or 8, and signed and unsigned compares. The other group does bitwise logic and conditional moves. The decoder drives in the 32-bit instruction word together with the values of the two source registers. The block returns the destination register index, the result, a write enable and a flag for an unrecognised function.

The register file sits outside this block. Source index 31 is treated as the constant zero. A write aimed at index 31 is dropped by deasserting the write enable. A conditional move whose test fails also deasserts the write enable, so the destination keeps its old value.

Top module: `op_alu`

## Requirements
- R1: The destination index output always equals instruction bits [4:0], and a write is only ever enabled for opcode (bits [31:26]) 0x10 or 0x11.
- R2: When instruction bit 12 is 1, operand B is instruction bits [20:13] zero-extended to 64 bits, and the Rb port value and the Rb field are ignored. When bit 12 is 0, operand B is the Rb value.
- R3: A source index of 31 in Ra (bits [25:21]) or Rb (bits [20:16]) reads as zero, whatever value the port carries.
- R4: With destination index 31 the write enable is 0 for every function.
- R5: In group 0x10, function 0x00 adds the low 32 bits and sign-extends the 32-bit sum to 64 bits. 0x20 is the 64-bit add and 0x29 is the 64-bit subtract A-B.
- R6: In group 0x10, 0x22 gives A*4+B, 0x2B gives A*4-B, 0x32 gives A*8+B and 0x3B gives A*8-B, all modulo 2^64.
- R7: In group 0x10, the compares write exactly 1 or 0: 0x2D equal, 0x1D unsigned less-than, 0x3D unsigned less-or-equal, 0x4D signed less-than, 0x6D signed less-or-equal.
- R8: In group 0x11, 0x00 gives A&B, 0x08 gives A&~B, 0x20 gives A|B, 0x28 gives A|~B, 0x40 gives A^B and 0x48 gives A^~B.
- R9: In group 0x11, the conditional moves give B as the result with the write enabled only when the test on A holds: 0x14 low bit set, 0x16 low bit clear, 0x24 zero, 0x26 non-zero, 0x44 negative, 0x46 non-negative, 0x64 less-or-equal zero, 0x66 greater than zero. When the test fails the write enable is 0.
- R10: A function code not listed for its group, or any opcode other than 0x10 and 0x11, sets the illegal flag to 1 and the write enable to 0. All listed codes give an illegal flag of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word |
| ra_val | input | 64 | Value read for source index Ra |
| rb_val | input | 64 | Value read for source index Rb |
| dst | output | 5 | Destination register index |
| result | output | 64 | Computed value |
| wr_en | output | 1 | Write the result to dst |
| illegal | output | 1 | Function or opcode not supported |

## Verification
The block holds no state, so any fault shows at once on the same inputs. It shows as a wrong result, a write enable set when it should be clear, or a missing illegal flag. The stimulus therefore pairs operands whose signed and unsigned orderings disagree, so the compares can show a swapped sign test. It includes a 32-bit carry into bit 31 that exposes a missing sign extension. It also uses a literal whose bit pattern overlaps the Rb field with the value 31, to separate the literal path from the zero-register path.

// File: rtl/op_alu.sv
module op_alu #(
  parameter int XLEN = 64
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  output logic [4:0]      dst,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic            illegal
);
  localparam logic [4:0] ZREG  = 5'd31;
  localparam logic [5:0] GRP_A = 6'h10;
  localparam logic [5:0] GRP_L = 6'h11;

  logic [5:0] opc;
  logic [6:0] fn;
  logic [XLEN-1:0] opa, opb, sum32;
  logic known, take;

  assign opc = insn[31:26];
  assign fn  = insn[11:5];
  assign dst = insn[4:0];

  assign opa = (insn[25:21] == ZREG) ? '0 : ra_val;
  assign opb = insn[12] ? XLEN'(insn[20:13])
             : ((insn[20:16] == ZREG) ? '0 : rb_val);

  assign sum32 = XLEN'(signed'(opa[31:0] + opb[31:0]));

  always_comb begin
    result = '0;
    known  = 1'b1;
    take   = 1'b1;
    if (opc == GRP_A) begin
      case (fn)
        7'h00: result = sum32;
        7'h20: result = opa + opb;
        7'h29: result = opa - opb;
        7'h22: result = (opa << 2) + opb;
        7'h2B: result = (opa << 2) - opb;
        7'h32: result = (opa << 3) + opb;
        7'h3B: result = (opa << 3) - opb;
        7'h2D: result = XLEN'(opa == opb);
        7'h1D: result = XLEN'(opa < opb);
        7'h3D: result = XLEN'(opa <= opb);
        7'h4D: result = XLEN'($signed(opa) < $signed(opb));
        7'h6D: result = XLEN'($signed(opa) <= $signed(opb));
        default: known = 1'b0;
      endcase
    end else if (opc == GRP_L) begin
      result = opb;
      case (fn)
        7'h00: result = opa & opb;
        7'h08: result = opa & ~opb;
        7'h20: result = opa | opb;
        7'h28: result = opa | ~opb;
        7'h40: result = opa ^ opb;
        7'h48: result = opa ^ ~opb;
        7'h14: take = opa[0];
        7'h16: take = ~opa[0];
        7'h24: take = (opa == '0);
        7'h26: take = (opa != '0);
        7'h44: take = opa[XLEN-1];
        7'h46: take = ~opa[XLEN-1];
        7'h64: take = opa[XLEN-1] | (opa == '0);
        7'h66: take = ~opa[XLEN-1] & (opa != '0);
        default: known = 1'b0;
      endcase
    end else begin
      known = 1'b0;
    end
    if (!known) result = '0;
  end

  assign illegal = ~known;
  assign wr_en   = known & take & (dst != ZREG);
endmodule

// File: rtl/op_alu_props.sv
module op_alu_props #(
  parameter int XLEN = 64
) (
  input logic [31:0]     insn,
  input logic [XLEN-1:0] ra_val,
  input logic [XLEN-1:0] rb_val,
  input logic [4:0]      dst,
  input logic [XLEN-1:0] result,
  input logic            wr_en,
  input logic            illegal
);
  logic [XLEN-1:0] b_seen;
  logic is_cmp, is_cmov;

  assign b_seen  = insn[12] ? XLEN'(insn[20:13])
                 : ((insn[20:16] == 5'd31) ? '0 : rb_val);
  assign is_cmp  = (insn[31:26] == 6'h10) &&
                   (insn[11:5] inside {7'h1D, 7'h2D, 7'h3D, 7'h4D, 7'h6D});
  assign is_cmov = (insn[31:26] == 6'h11) &&
                   (insn[11:5] inside {7'h14, 7'h16, 7'h24, 7'h26,
                                       7'h44, 7'h46, 7'h64, 7'h66});

  always_comb begin
    a_r1_dst_field: assert (dst == insn[4:0]);
    a_r1_group_only: assert (!wr_en || insn[31:26] inside {6'h10, 6'h11});
    a_r4_zero_dst: assert (!(wr_en && dst == 5'd31));
    a_r10_no_write: assert (!(illegal && wr_en));
    a_r7_bool: assert (!is_cmp || result[XLEN-1:1] == '0);
    a_r9_move_b: assert (!(is_cmov && wr_en) || result == b_seen);
  end
endmodule

bind op_alu op_alu_props #(.XLEN(XLEN)) u_props (.*);

// File: tb/test_op_alu.sv
module test_op_alu;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] insn;
  logic [63:0] ra_val, rb_val, result;
  logic [4:0]  dst;
  logic wr_en, illegal;

  op_alu i_op_alu (.insn(insn), .ra_val(ra_val), .rb_val(rb_val),
                   .dst(dst), .result(result), .wr_en(wr_en), .illegal(illegal));

  typedef struct packed {
    logic [31:0] insn;
    logic [63:0] a, b, res;
    logic        we, ill;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t v(input logic [5:0] op, input logic [4:0] ra,
                             input logic [7:0] rbl, input logic lit,
                             input logic [6:0] fn, input logic [4:0] rc,
                             input logic [63:0] a, input logic [63:0] b,
                             input logic [63:0] res, input logic we,
                             input logic ill, input logic [7:0] req);
    vec_t t;
    t.insn = {op, ra, (lit ? {rbl, 1'b1} : {rbl[4:0], 4'b0000}), fn, rc};
    t.a = a; t.b = b; t.res = res; t.we = we; t.ill = ill; t.req = req;
    return t;
  endfunction

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int N = 36;
  localparam vec_t VECS [N] = '{
    // R5
    v(6'h10, 1, 2, 0, 7'h00, 3, 64'h7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000, 1, 0, 5),
    v(6'h10, 1, 2, 0, 7'h20, 3, 64'd5, 64'd7, 64'd12, 1, 0, 5),
    v(6'h10, 1, 2, 0, 7'h29, 3, 64'd3, 64'd5, ONES - 64'd1, 1, 0, 5),
    // R6
    v(6'h10, 1, 2, 0, 7'h22, 3, 64'd3, 64'd1, 64'd13, 1, 0, 6),
    v(6'h10, 1, 2, 0, 7'h2B, 3, 64'd2, 64'd10, ONES - 64'd1, 1, 0, 6),
    v(6'h10, 1, 2, 0, 7'h32, 3, 64'd2, 64'd1, 64'd17, 1, 0, 6),
    v(6'h10, 1, 2, 0, 7'h3B, 3, 64'd1, 64'd3, 64'd5, 1, 0, 6),
    // R7
    v(6'h10, 1, 2, 0, 7'h1D, 3, 64'd1, ONES, 64'd1, 1, 0, 7),
    v(6'h10, 1, 2, 0, 7'h4D, 3, 64'd1, ONES, 64'd0, 1, 0, 7),
    v(6'h10, 1, 2, 0, 7'h2D, 3, 64'd9, 64'd9, 64'd1, 1, 0, 7),
    v(6'h10, 1, 2, 0, 7'h3D, 3, 64'd5, 64'd5, 64'd1, 1, 0, 7),
    v(6'h10, 1, 2, 0, 7'h6D, 3, ONES, 64'd0, 64'd1, 1, 0, 7),
    // R8
    v(6'h11, 1, 2, 0, 7'h00, 3, 64'hF0F0, 64'hFF00, 64'hF000, 1, 0, 8),
    v(6'h11, 1, 2, 0, 7'h08, 3, 64'hF0F0, 64'hFF00, 64'h00F0, 1, 0, 8),
    v(6'h11, 1, 2, 0, 7'h20, 3, 64'hF0F0, 64'hFF00, 64'hFFF0, 1, 0, 8),
    v(6'h11, 1, 2, 0, 7'h28, 3, 64'h0, 64'hFFFF_FFFF_FFFF_0000, 64'hFFFF, 1, 0, 8),
    v(6'h11, 1, 2, 0, 7'h40, 3, 64'hF0F0, 64'hFF00, 64'h0FF0, 1, 0, 8),
    v(6'h11, 1, 2, 0, 7'h48, 3, 64'h0, 64'h0, ONES, 1, 0, 8),
    // R9
    v(6'h11, 1, 2, 0, 7'h14, 3, 64'd1, 64'h55, 64'h55, 1, 0, 9),
    v(6'h11, 1, 2, 0, 7'h14, 3, 64'd2, 64'h55, 64'h55, 0, 0, 9),
    v(6'h11, 1, 2, 0, 7'h16, 3, 64'd2, 64'h66, 64'h66, 1, 0, 9),
    v(6'h11, 1, 2, 0, 7'h24, 3, 64'd0, 64'h77, 64'h77, 1, 0, 9),
    v(6'h11, 1, 2, 0, 7'h26, 3, 64'd0, 64'h77, 64'h77, 0, 0, 9),
    v(6'h11, 1, 2, 0, 7'h44, 3, ONES, 64'h88, 64'h88, 1, 0, 9),
    v(6'h11, 1, 2, 0, 7'h46, 3, ONES, 64'h88, 64'h88, 0, 0, 9),
    v(6'h11, 1, 2, 0, 7'h64, 3, 64'd0, 64'h99, 64'h99, 1, 0, 9),
    v(6'h11, 1, 2, 0, 7'h66, 3, 64'd0, 64'h99, 64'h99, 0, 0, 9),
    v(6'h11, 1, 2, 0, 7'h66, 3, 64'd5, 64'h99, 64'h99, 1, 0, 9),
    // R2
    v(6'h10, 1, 8'hFF, 1, 7'h20, 3, 64'd1, 64'h1234, 64'h100, 1, 0, 2),
    // R3
    v(6'h10, 31, 2, 0, 7'h20, 3, 64'd99, 64'd5, 64'd5, 1, 0, 3),
    v(6'h10, 1, 31, 0, 7'h20, 3, 64'd4, 64'd77, 64'd4, 1, 0, 3),
    // R4
    v(6'h10, 1, 2, 0, 7'h20, 31, 64'd4, 64'd4, 64'd8, 0, 0, 4),
    // R10
    v(6'h10, 1, 2, 0, 7'h01, 3, 64'd1, 64'd1, 64'd0, 0, 1, 10),
    v(6'h11, 1, 2, 0, 7'h7F, 3, 64'd1, 64'd1, 64'd0, 0, 1, 10),
    v(6'h12, 1, 2, 0, 7'h20, 3, 64'd1, 64'd1, 64'd0, 0, 1, 10),
    // R1
    v(6'h10, 1, 2, 0, 7'h20, 7, 64'd1, 64'd1, 64'd2, 1, 0, 1)
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input logic [7:0] req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    insn = i; ra_val = a; rb_val = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    insn = '0; ra_val = '0; rb_val = '0;
    @(posedge clk);
    #1;
    // all-zero word: opcode 0 is outside both groups (R10)
    chk(10, "idle illegal", 64'(illegal), 64'd1);
    chk(10, "idle wr_en", 64'(wr_en), 64'd0);
    chk(1, "idle dst", 64'(dst), 64'd0);

    for (int k = 0; k < N; k++) begin
      apply(VECS[k].insn, VECS[k].a, VECS[k].b);
      chk(1, "dst", 64'(dst), 64'(VECS[k].insn[4:0]));
      chk(VECS[k].req, "wr_en", 64'(wr_en), 64'(VECS[k].we));
      chk(VECS[k].req, "illegal", 64'(illegal), 64'(VECS[k].ill));
      if (VECS[k].we)
        chk(VECS[k].req, "result", result, VECS[k].res);
    end

    // R2: literal 0xF8 puts 31 in the Rb field; must not read as zero
    apply({6'h10, 5'd1, 8'hF8, 1'b1, 7'h20, 5'd3}, 64'd2, 64'hDEAD);
    chk(2, "literal over rb31", result, 64'hFA);
    // R3 with R4: both sources 31 and dest 31
    apply({6'h11, 5'd31, 5'd31, 4'b0000, 7'h20, 5'd31}, ONES, ONES);
    chk(4, "zero dst wr_en", 64'(wr_en), 64'd0);
    apply({6'h11, 5'd31, 5'd31, 4'b0000, 7'h20, 5'd5}, ONES, ONES);
    chk(3, "both zero sources", result, 64'd0);
    // R5: 32-bit add wraps without carry into the upper half
    apply({6'h10, 5'd1, 5'd2, 4'b0000, 7'h00, 5'd3}, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    chk(5, "add32 wrap", result, 64'd1);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 10000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule